// File: doc/BRIEF.md
# Stateful Implication Logic Sequencer

This block computes one of five Boolean functions of two input bits. It has no logic gate that forms the result. Instead it keeps a bank of seven single-bit storage cells and works through a short fixed microprogram, one operation per clock.

There are two primitives:
- A clear step, which writes 0 into the cells that need it.
- An implication step, which reads one source cell and rewrites one target cell with (NOT source) OR (old target). The source and every other cell keep their values.

A start strobe loads the two operand cells and clears the rest in the same cycle. The sequencer then applies the implication steps of the selected function in order. It flags busy while the steps run and pulses done for one cycle when the result cell holds the answer.

The result stays readable after done, because the cells persist until the next accepted start. A new start may be given in the done cycle itself, so results can follow back to back. The control and status pins are plain level and strobe signals; there is no data back-pressure.

Top module: `imply_logic_seq`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all 0.
- R2: A start_i pulse is accepted when busy_o is low and op_i is a legal code. In that cycle a_i, b_i and op_i are captured and the work cells are cleared. Each later cycle applies exactly one implication step, rewriting only its target cell as (NOT source) OR (old target).
- R3: busy_o is high for exactly N cycles following the accepting clock edge, and done_o rises in the cycle after that. N is 1 for NOT, 2 for NAND, 2 for OR, 3 for AND and 8 for XOR.
- R4: op_i code 0 (NOT) yields NOT a. Code 3 (NAND) yields NOT (a AND b).
- R5: op_i code 1 (AND) yields a AND b. Code 2 (OR) yields a OR b, with the result left in the second operand cell.
- R6: op_i code 4 (XOR) yields a XOR b, using four work cells and an output cell.
- R7: done_o is high for exactly one cycle, is never high together with busy_o, and result_o is valid in that cycle.
- R8: While busy_o is high, start_i is ignored, and changes on op_i, a_i and b_i have no effect on the running result.
- R9: A start_i with op_i codes 5, 6 or 7 is ignored: busy_o and done_o stay low and result_o keeps its previous value.
- R10: After done_o, result_o keeps its value until the next accepted start.
- R11: A start_i given in the done cycle is accepted, and the next operation runs at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request strobe |
| op_i | input | 3 | Function select: 0 NOT, 1 AND, 2 OR, 3 NAND, 4 XOR |
| a_i | input | 1 | First operand bit |
| b_i | input | 1 | Second operand bit |
| busy_o | output | 1 | High while implication steps run |
| done_o | output | 1 | One-cycle pulse when result is valid |
| result_o | output | 1 | Result bit, read from the selected result cell |

## Verification
A wrong step source or target, or a cell that is not cleared at load, corrupts the result. This shows at result_o in the done cycle of the first operand pair that exposes it, which is at most nine cycles after the start. Random operand and function mixes reach every cell path within a few operations. A step counter or last-step flag that is off by one shows at once as a busy run of the wrong length, or as done arriving early or late. An internal step that rewrote the wrong cell, or cleared a set cell, is also caught by the step-level properties in the cycle it happens.

// File: rtl/imply_seq_pkg.sv
package imply_seq_pkg;
  localparam int NUM_CELLS = 7;
  localparam int CELL_W    = $clog2(NUM_CELLS);
  localparam int MAX_STEPS = 8;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  typedef logic [CELL_W-1:0] cell_idx_t;

  typedef enum logic [2:0] {
    OP_NOT  = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_NAND = 3'd3,
    OP_XOR  = 3'd4
  } op_e;

  // cell roles
  localparam cell_idx_t C_P   = 3'd0;
  localparam cell_idx_t C_Q   = 3'd1;
  localparam cell_idx_t C_W1  = 3'd2;
  localparam cell_idx_t C_W2  = 3'd3;
  localparam cell_idx_t C_T1  = 3'd4;
  localparam cell_idx_t C_T2  = 3'd5;
  localparam cell_idx_t C_OUT = 3'd6;

  typedef struct packed {
    cell_idx_t src;
    cell_idx_t dst;
    logic      last;
  } step_t;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/imply_microrom.sv
module imply_microrom
  import imply_seq_pkg::*;
(
  input  op_e                op,
  input  logic [STEP_W-1:0]  idx,
  output step_t              step,
  output cell_idx_t          res_cell
);
  function automatic step_t mk(input cell_idx_t s, input cell_idx_t d, input logic l);
    step_t t;
    t.src  = s;
    t.dst  = d;
    t.last = l;
    return t;
  endfunction

  always_comb begin
    step     = mk(C_P, C_OUT, 1'b1);
    res_cell = C_OUT;
    unique case (op)
      OP_NOT: step = mk(C_P, C_OUT, 1'b1);
      OP_NAND: begin
        case (idx)
          3'd0:    step = mk(C_P, C_OUT, 1'b0);
          default: step = mk(C_Q, C_OUT, 1'b1);
        endcase
      end
      OP_AND: begin
        case (idx)
          3'd0:    step = mk(C_Q,  C_T1,  1'b0);
          3'd1:    step = mk(C_P,  C_T1,  1'b0);
          default: step = mk(C_T1, C_OUT, 1'b1);
        endcase
      end
      OP_OR: begin
        res_cell = C_Q;
        case (idx)
          3'd0:    step = mk(C_P,   C_OUT, 1'b0);
          default: step = mk(C_OUT, C_Q,   1'b1);
        endcase
      end
      OP_XOR: begin
        case (idx)
          3'd0:    step = mk(C_P,  C_W1,  1'b0);
          3'd1:    step = mk(C_W1, C_T1,  1'b0);
          3'd2:    step = mk(C_Q,  C_W2,  1'b0);
          3'd3:    step = mk(C_W2, C_T2,  1'b0);
          3'd4:    step = mk(C_P,  C_T2,  1'b0);
          3'd5:    step = mk(C_Q,  C_T1,  1'b0);
          3'd6:    step = mk(C_T1, C_OUT, 1'b0);
          default: step = mk(C_T2, C_OUT, 1'b1);
        endcase
      end
      default: step = mk(C_P, C_OUT, 1'b1);
    endcase
  end
endmodule

// File: rtl/imply_cell_array.sv
module imply_cell_array
  import imply_seq_pkg::*;
#(
  parameter int NCELL = NUM_CELLS,
  parameter int IDX_W = CELL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             a,
  input  logic             b,
  input  logic             step_en,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  output logic [NCELL-1:0] cells
);
  logic src_val;
  assign src_val = cells[src];

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic load_val;
    if (i == int'(C_P)) begin : g_p
      assign load_val = a;
    end else if (i == int'(C_Q)) begin : g_q
      assign load_val = b;
    end else begin : g_work
      assign load_val = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[i] <= 1'b0;
      end else if (load) begin
        cells[i] <= load_val;
      end else if (step_en && (dst == IDX_W'(i))) begin
        cells[i] <= ~src_val | cells[i];
      end
    end
  end
endmodule

// File: rtl/imply_seq_ctrl.sv
module imply_seq_ctrl
  import imply_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_in,
  input  logic              last_step,
  output logic              load,
  output logic              step_en,
  output logic [STEP_W-1:0] idx,
  output op_e               op_q,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;
  state_e state;

  assign busy    = (state == S_RUN);
  assign done    = (state == S_DONE);
  assign step_en = busy;
  assign load    = !busy && start && op_legal(op_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      op_q  <= OP_NOT;
    end else if (load) begin
      state <= S_RUN;
      idx   <= '0;
      op_q  <= op_e'(op_in);
    end else begin
      unique case (state)
        S_RUN: begin
          if (last_step) state <= S_DONE;
          else           idx   <= idx + 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imply_logic_seq.sv
module imply_logic_seq
  import imply_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       result_o
);
  logic                  load;
  logic                  step_en;
  logic [STEP_W-1:0]     idx;
  op_e                   op_q;
  step_t                 step;
  cell_idx_t             res_cell;
  logic [NUM_CELLS-1:0]  cells;

  imply_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .op_in     (op_i),
    .last_step (step.last),
    .load      (load),
    .step_en   (step_en),
    .idx       (idx),
    .op_q      (op_q),
    .busy      (busy_o),
    .done      (done_o)
  );

  imply_microrom u_rom (
    .op       (op_q),
    .idx      (idx),
    .step     (step),
    .res_cell (res_cell)
  );

  imply_cell_array #(.NCELL(NUM_CELLS), .IDX_W(CELL_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .a       (a_i),
    .b       (b_i),
    .step_en (step_en),
    .src     (step.src),
    .dst     (step.dst),
    .cells   (cells)
  );

  assign result_o = cells[res_cell];
endmodule

// File: rtl/imply_seq_checker.sv
module imply_seq_checker
  import imply_seq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [NUM_CELLS-1:0] cells
);
  logic [STEP_W:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  always_comb begin
    if (rst_n) begin
      p_busy_len_r3: assert (run_len <= (STEP_W+1)'(MAX_STEPS))
        else $error("busy run longer than the longest microprogram");
    end
  end

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_one_cell_per_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> ($countones(cells ^ $past(cells)) <= 1));

  p_step_never_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> (($past(cells) & ~cells) == '0));
endmodule

bind imply_logic_seq imply_seq_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cells   (cells)
);

// File: tb/sim_imply_logic_seq.sv
`timescale 1ns/1ps
module sim_imply_logic_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic       a_i = 1'b0;
  logic       b_i = 1'b0;
  logic       busy_o, done_o, result_o;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  imply_logic_seq u0 (.*);

  function automatic logic exp_res(input logic [2:0] op, input logic a, input logic b);
    case (op)
      3'd0: return ~a;
      3'd1: return a & b;
      3'd2: return a | b;
      3'd3: return ~(a & b);
      default: return a ^ b;
    endcase
  endfunction

  function automatic int exp_steps(input logic [2:0] op);
    case (op)
      3'd0: return 1;
      3'd1: return 3;
      3'd2: return 2;
      3'd3: return 2;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // chained: start_i already driven in the current (done) cycle
  task automatic run_op(input logic [2:0] op, input logic a, input logic b,
                        input bit disturb, input bit chained);
    int busy_cnt = 0;
    int done_at = 0;
    if (!chained) @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    for (int cyc = 1; cyc <= 14; cyc++) begin
      @(negedge clk);
      if (busy_o) busy_cnt++;
      if (done_o) begin
        done_at = cyc;
        start_i = 1'b0;
        break;
      end
      start_i = disturb;
      if (disturb) begin
        op_i = 3'(op + 3'd1); a_i = ~a_i; b_i = ~b_i;
      end
    end
    check("R3 busy length", busy_cnt, exp_steps(op));
    check("R3 done latency", done_at, exp_steps(op) + 1);
    check("R7 busy low in done cycle", busy_o, 0);
    case (op)
      3'd0, 3'd3: check("R4 result", result_o, exp_res(op, a, b));
      3'd1, 3'd2: check("R5 result", result_o, exp_res(op, a, b));
      default:    check("R6 result", result_o, exp_res(op, a, b));
    endcase
    if (disturb) check("R8 ignored mid-run", result_o, exp_res(op, a, b));
  endtask

  initial begin
    logic kept;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 result", result_o, 0);
    rst_n = 1'b1;

    // directed: every op, every operand pair (R2 capture)
    for (int op = 0; op < 5; op++)
      for (int ab = 0; ab < 4; ab++)
        run_op(3'(op), ab[1], ab[0], 1'b0, 1'b0);

    // R7 done is a single cycle
    @(negedge clk);
    check("R7 done one cycle", done_o, 0);

    // R10 hold after done
    run_op(3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 result held", result_o, 1);
    check("R10 idle", busy_o, 0);

    // R9 illegal codes
    for (int c = 5; c < 8; c++) begin
      kept = result_o;
      start_i = 1'b1; op_i = 3'(c); a_i = 1'b0; b_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      check("R9 busy stays low", busy_o, 0);
      repeat (2) @(negedge clk);
      check("R9 no done", done_o, 0);
      check("R9 result kept", result_o, kept);
    end

    // R8 disturbance while busy
    run_op(3'd4, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(3'd1, 1'b1, 1'b1, 1'b1, 1'b0);

    // R11 back to back: start given in done cycle
    run_op(3'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(3'd2, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R11 chained result", result_o, 1);
    run_op(3'd0, 1'b0, 1'b0, 1'b0, 1'b1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 4));
      run_op(rop, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
             1'($urandom_range(0, 2) == 0));
    end

    @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule